// File: doc/BRIEF.md
# Six-Phase Accumulator Computer

This block is a very small stored-program computer. An 8-bit program counter is not used. Instead, a 4-bit program counter, a 4-bit memory address register, an instruction register, an accumulator, an operand register and an output register all meet on one 8-bit shared bus. A 16-word by 8-bit read-only program image is supplied as a parameter. The image holds both instructions and data. A six-phase sequencer drives one control word per clock cycle. Phases 1 to 3 fetch an instruction, and phases 4 to 6 carry it out.

Each instruction is 8 bits wide. The opcode is in bits 7:4, and bits 3:0 hold the operand address for the memory-reading instructions. The only visible result is the output register and a halted flag. The bus value and the accumulator are also brought out as probes, so that the transfer sequence can be observed.

Top module: `accm_core`

## Requirements
- R1: While reset is asserted, and after it is released, the output register, the accumulator and the halted flag read zero. Execution begins with a fetch from address 0.
- R2: Every instruction takes exactly six clock cycles. Phase 1 puts the program counter on the bus. Phase 2 puts the program word at that address on the bus. The program counter advances by one only at the end of phase 3.
- R3: When a 4-bit source drives the bus, the upper four bus bits are zero. This applies to the program counter in phase 1 and to the instruction's address field in phase 4 of opcodes 0000, 0001 and 0010.
- R4: Opcode 0000 loads the accumulator with the program word at the address field. The load happens at the end of phase 5.
- R5: Opcode 0001 sets the accumulator to the accumulator plus the program word at the address field, modulo 256. The result is written at the end of phase 6.
- R6: Opcode 0010 sets the accumulator to the accumulator minus the program word at the address field, modulo 256. The subtraction adds the two's complement of the operand, and the result is written at the end of phase 6.
- R7: Opcode 1110 copies the accumulator into the output register at the end of phase 4. At all other times the output register holds its value.
- R8: Opcode 1111 sets the halted flag at the end of phase 4. After that, no register changes and the bus stays zero until reset.
- R9: Any opcode other than 0000, 0001, 0010, 1110 and 1111 leaves the accumulator and the output register unchanged.
- R10: In any phase, at most one source drives the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; the block synchronizes its release over two edges |
| out_o | output | 8 | Output register |
| halted_o | output | 1 | High once a halt instruction has executed |
| bus_o | output | 8 | Probe of the shared bus value |
| acc_o | output | 8 | Probe of the accumulator |

## Verification
The hardest situations to reach from the ports are the internal transfers. These are the zero-extended 4-bit bus sources, the phase in which each register changes, and the quiet state after a halt. They are only visible through the probes, at exact cycle offsets.

The stimulus is a single program image. It chains a load, additions and subtractions that wrap past 255 and below 0, an undefined opcode and several output instructions, and it ends in a halt. The bench samples the probes on the cycles where the six-phase schedule says each value must first appear, and also on the cycle before. A second reset after the halt shows that execution restarts from address 0.

// File: rtl/accm_pkg.sv
`timescale 1ns/1ps
package accm_pkg;

  typedef struct packed {
    logic inc_pc;   // program counter advance
    logic drv_pc;   // program counter onto bus
    logic ld_mar;   // address register load
    logic drv_rom;  // program word onto bus
    logic ld_ir;    // instruction register load
    logic drv_arg;  // address field onto bus
    logic ld_acc;   // accumulator load
    logic drv_acc;  // accumulator onto bus
    logic sub;      // ALU subtract select
    logic drv_alu;  // ALU result onto bus
    logic ld_opb;   // operand register load
    logic ld_out;   // output register load
  } ctrl_t;

  typedef enum logic [2:0] {
    PH1 = 3'd0, PH2 = 3'd1, PH3 = 3'd2,
    PH4 = 3'd3, PH5 = 3'd4, PH6 = 3'd5
  } phase_e;

  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_LOAD = 4'h0;
  localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h2;
  localparam logic [OP_W-1:0] OP_SHOW = 4'hE;
  localparam logic [OP_W-1:0] OP_STOP = 4'hF;

  // bus source slots
  localparam int SRC_PC  = 0;
  localparam int SRC_ROM = 1;
  localparam int SRC_ARG = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_ALU = 4;
  localparam int SRC_N   = 5;

endpackage

// File: rtl/accm_ctl.sv
`timescale 1ns/1ps
module accm_ctl
  import accm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           cw_o,
  output phase_e          ph_o,
  output logic            halted_o
);

  phase_e ph_q, ph_d;
  logic   halt_q, halt_d;
  logic   mem_op;

  assign mem_op = (op_i == OP_LOAD) || (op_i == OP_ADD) || (op_i == OP_SUB);

  always_comb begin
    ph_d   = ph_q;
    halt_d = halt_q;
    if (!halt_q) begin
      ph_d = (ph_q == PH6) ? PH1 : phase_e'(ph_q + 3'd1);
      if (ph_q == PH4 && op_i == OP_STOP) halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH1;
      halt_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      halt_q <= halt_d;
    end
  end

  always_comb begin
    cw_o = '0;
    if (!halt_q) begin
      unique case (ph_q)
        PH1: begin cw_o.drv_pc = 1'b1; cw_o.ld_mar = 1'b1; end
        PH2: begin cw_o.drv_rom = 1'b1; cw_o.ld_ir = 1'b1; end
        PH3: cw_o.inc_pc = 1'b1;
        PH4: begin
          if (mem_op) begin cw_o.drv_arg = 1'b1; cw_o.ld_mar = 1'b1; end
          if (op_i == OP_SHOW) begin cw_o.drv_acc = 1'b1; cw_o.ld_out = 1'b1; end
        end
        PH5: begin
          if (mem_op) cw_o.drv_rom = 1'b1;
          if (op_i == OP_LOAD) cw_o.ld_acc = 1'b1;
          else if (mem_op)     cw_o.ld_opb = 1'b1;
        end
        PH6: begin
          if (op_i == OP_ADD || op_i == OP_SUB) begin
            cw_o.drv_alu = 1'b1;
            cw_o.ld_acc  = 1'b1;
            cw_o.sub     = (op_i == OP_SUB);
          end
        end
        default: cw_o = '0;
      endcase
    end
  end

  assign ph_o     = ph_q;
  assign halted_o = halt_q;

  // R8: once stopped, the sequencer stays stopped and frozen
  p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(ph_q)));

  // R2: the sequencer walks the six phases in order while running
  p_phase_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && ph_q == PH6) |=> (ph_q == PH1));

endmodule

// File: rtl/accm_bus.sv
`timescale 1ns/1ps
module accm_bus #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        en_i,
  input  logic [N-1:0][W-1:0] src_i,
  output logic [W-1:0]        bus_o
);

  logic [N-1:0][W-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated[g] = src_i[g] & {W{en_i[g]}};
  end

  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N; i++) bus_o = bus_o | gated[i];
  end

  // R10: never two drivers on the shared bus
  p_single_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_i));

endmodule

// File: rtl/accm_alu.sv
`timescale 1ns/1ps
module accm_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);

  // two's complement subtract: invert operand and add carry-in
  assign y_o = a_i + (b_i ^ {W{sub_i}}) + {{(W-1){1'b0}}, sub_i};

endmodule

// File: rtl/accm_core.sv
`timescale 1ns/1ps
module accm_core
  import accm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] PROGRAM =
    128'h9C70C8E0F0E02DE01E5AE02FE01EE00D
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] out_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] acc_o
);

  localparam int DEPTH = 2**ADDR_W;
  localparam int ARG_W = DATA_W - OP_W;

  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  ctrl_t  cw;
  phase_e ph;
  logic   halted;

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] ir_q, ir_d, acc_q, acc_d, opb_q, opb_d, out_q, out_d;
  logic [DATA_W-1:0] bus, rom_q, alu_y;

  logic [DEPTH-1:0][DATA_W-1:0] rom_arr;
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom_arr[g] = PROGRAM[g*DATA_W +: DATA_W];
  end
  assign rom_q = rom_arr[mar_q];

  accm_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .op_i     (ir_q[DATA_W-1 -: OP_W]),
    .cw_o     (cw),
    .ph_o     (ph),
    .halted_o (halted)
  );

  accm_alu #(.W(DATA_W)) u_alu (
    .a_i   (acc_q),
    .b_i   (opb_q),
    .sub_i (cw.sub),
    .y_o   (alu_y)
  );

  logic [SRC_N-1:0]             bus_en;
  logic [SRC_N-1:0][DATA_W-1:0] bus_src;

  assign bus_en[SRC_PC]   = cw.drv_pc;
  assign bus_en[SRC_ROM]  = cw.drv_rom;
  assign bus_en[SRC_ARG]  = cw.drv_arg;
  assign bus_en[SRC_ACC]  = cw.drv_acc;
  assign bus_en[SRC_ALU]  = cw.drv_alu;
  assign bus_src[SRC_PC]  = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
  assign bus_src[SRC_ROM] = rom_q;
  assign bus_src[SRC_ARG] = {{(DATA_W-ARG_W){1'b0}}, ir_q[ARG_W-1:0]};
  assign bus_src[SRC_ACC] = acc_q;
  assign bus_src[SRC_ALU] = alu_y;

  accm_bus #(.W(DATA_W), .N(SRC_N)) u_bus (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en_i  (bus_en),
    .src_i (bus_src),
    .bus_o (bus)
  );

  always_comb begin
    pc_d  = cw.inc_pc  ? pc_q + 1'b1       : pc_q;
    mar_d = cw.ld_mar  ? bus[ADDR_W-1:0]   : mar_q;
    ir_d  = cw.ld_ir   ? bus               : ir_q;
    acc_d = cw.ld_acc  ? bus               : acc_q;
    opb_d = cw.ld_opb  ? bus               : opb_q;
    out_d = cw.ld_out  ? bus               : out_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      opb_q <= '0;
      out_q <= '0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      ir_q  <= ir_d;
      acc_q <= acc_d;
      opb_q <= opb_d;
      out_q <= out_d;
    end
  end

  assign out_o    = out_q;
  assign halted_o = halted;
  assign bus_o    = bus;
  assign acc_o    = acc_q;

  // R2: program counter moves by one, and only after phase 3
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pc_q != $past(pc_q)) |-> ($past(ph) == PH3 && pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  // R7: output register only changes after phase 4, taking the accumulator
  p_out_copy_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (out_q != $past(out_q)) |-> ($past(ph) == PH4 && out_q == $past(acc_q)));

  // R4: accumulator only written after phase 5 or 6
  p_acc_phase_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (acc_q != $past(acc_q)) |-> ($past(ph) == PH5 || $past(ph) == PH6));

endmodule

// File: tb/tb_accm_core.sv
`timescale 1ns/1ps
module tb_accm_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] out_o, bus_o, acc_o;
  logic       halted_o;

  int total = 0;
  int bad   = 0;
  int ecount = 0;

  always #2.5 clk = ~clk;

  accm_core #(
    .ADDR_W (4),
    .DATA_W (8),
    .PROGRAM(128'h9C70C8E0F0E02DE01E5AE02FE01EE00D)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_o    (out_o),
    .halted_o (halted_o),
    .bus_o    (bus_o),
    .acc_o    (acc_o)
  );

  // {edge after reset release, probe (0 out,1 halted,2 acc,3 bus), expected, requirement}
  localparam int NV = 24;
  localparam logic [29:0] VEC [NV] = '{
    {16'd2,   2'd3, 8'h00, 4'd1},  // R1 first fetch address 0
    {16'd3,   2'd3, 8'h0D, 4'd2},  // R2 phase 2 word 0
    {16'd6,   2'd2, 8'd0,  4'd4},  // R4 before load
    {16'd7,   2'd2, 8'd200,4'd4},  // R4 after phase 5
    {16'd8,   2'd3, 8'h01, 4'd3},  // R3 pc=1 zero-extended
    {16'd11,  2'd0, 8'd0,  4'd7},  // R7 before show
    {16'd12,  2'd0, 8'd200,4'd7},  // R7 after phase 4
    {16'd19,  2'd2, 8'd200,4'd5},  // R5 before sum written
    {16'd20,  2'd2, 8'd56, 4'd5},  // R5 200+112 wraps
    {16'd23,  2'd0, 8'd200,4'd7},  // R7 holds
    {16'd24,  2'd0, 8'd56, 4'd5},  // R5 shown
    {16'd29,  2'd3, 8'h0F, 4'd3},  // R3 address field on bus
    {16'd32,  2'd3, 8'h05, 4'd3},  // R3 pc=5
    {16'd33,  2'd3, 8'hE0, 4'd2},  // R2 word 5 on bus
    {16'd36,  2'd0, 8'd156,4'd6},  // R6 56-156 wraps
    {16'd44,  2'd2, 8'd156,4'd9},  // R9 undefined opcode no effect
    {16'd53,  2'd0, 8'd156,4'd9},  // R9 output untouched
    {16'd54,  2'd0, 8'd12, 4'd5},  // R5 156+112 wraps
    {16'd66,  2'd0, 8'd68, 4'd6},  // R6 12-200 wraps
    {16'd71,  2'd1, 8'd0,  4'd8},  // R8 not yet stopped
    {16'd72,  2'd1, 8'd1,  4'd8},  // R8 stopped after phase 4
    {16'd150, 2'd0, 8'd68, 4'd8},  // R8 output frozen
    {16'd150, 2'd2, 8'd68, 4'd8},  // R8 accumulator frozen
    {16'd150, 2'd3, 8'h00, 4'd8}   // R8 bus idle
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_to(input int cyc);
    while (ecount < cyc) begin
      @(posedge clk);
      ecount++;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, out_o, 8'd0);
    check(1, acc_o, 8'd0);
    check(1, {7'd0, halted_o}, 8'd0);
    rst_n = 1'b1;
    ecount = 0;

    for (int i = 0; i < NV; i++) begin
      run_to(int'(VEC[i][29:14]));
      case (VEC[i][13:12])
        2'd0: check(int'(VEC[i][3:0]), out_o, VEC[i][11:4]);
        2'd1: check(int'(VEC[i][3:0]), {7'd0, halted_o}, VEC[i][11:4]);
        2'd2: check(int'(VEC[i][3:0]), acc_o, VEC[i][11:4]);
        default: check(int'(VEC[i][3:0]), bus_o, VEC[i][11:4]);
      endcase
    end

    // R1: reset after a halt clears state immediately and restarts at address 0
    #1 rst_n = 1'b0;
    #1;
    check(1, out_o, 8'd0);
    check(1, {7'd0, halted_o}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ecount = 0;
    run_to(11);
    check(1, out_o, 8'd0);
    run_to(12);
    check(1, out_o, 8'd200);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule